// File: doc/BRIEF.md
# Conversion Result Queue with Interrupt Registers

This block sits between a converter that produces result words and a processor that collects them. Each result arrives with a one-cycle valid strobe and is appended to a 16-entry, 16-bit queue. The processor reaches the block through a simple synchronous register bus. A request lasts one cycle and is answered one cycle later with an acknowledge pulse, read data and an error flag. Reading the data offset removes the oldest result from the queue.

An occupancy register gives the number of queued words. A status bit records that the queue holds data. Three conditions drive the interrupt output: a global enable, a per-source enable and that status bit. A control register holds the conversion enable bit and a settle-multiplier field, and both are presented on output pins for the converter. A result that arrives while the queue is full is discarded without notice.

Top module: `smpq_regblock`

## Requirements
- R1: After synchronous reset, every register reads zero, the occupancy reads 0, and `irq`, `conv_en` and `settle_mult` are low.
- R2: The queue holds up to 16 words of 16 bits and returns them oldest first. A word strobed in while 16 are held is dropped, and the held contents and count do not change.
- R3: Every bus request is acknowledged on the following cycle. A read of offset 0x104 pops the oldest word and returns it in bits [15:0], with bits [31:16] zero.
- R4: A read of offset 0x104 while the queue is empty returns `bus_err`=1 with the acknowledge, and the occupancy stays 0.
- R5: Offset 0x108 reads the occupancy as a binary count in bits [4:0], from 0 to 16.
- R6: Status bit 0 at offset 0x020 is set on the cycle after any cycle in which the queue is non-empty. Writing 1 to it toggles it. Once the queue is empty, the bit keeps its value until it is toggled.
- R7: `irq` is registered and equals the AND of global enable bit 0 (offset 0x01C), per-source enable bit 0 (offset 0x028) and status bit 0, one cycle after those bits change.
- R8: Offset 0x100 is the control register. Bit 0 is the conversion enable and drives `conv_en`. Bits [4:1] are the settle multiplier and drive `settle_mult`. The register reads back as written.
- R9: A word strobed in during the same cycle as a pop of a non-empty, non-full queue leaves the occupancy unchanged.
- R10: Writes to offsets 0x104 and 0x108 have no effect. Reads of unmapped offsets return zero without an error.
- R11: Offsets 0x01C and 0x028 each store only bit 0. Their other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | One-cycle register access request |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Response pulse, one cycle after the request |
| bus_err | output | 1 | Error flag with the response (empty queue read) |
| bus_rdata | output | 32 | Read data with the response |
| smp_valid | input | 1 | Result word strobe |
| smp_data | input | 16 | Result word |
| conv_en | output | 1 | Conversion enable from the control register |
| settle_mult | output | 4 | Settle multiplier from the control register |
| irq | output | 1 | Level interrupt |

## Verification
Bus responses appear on the cycle after the request edge. A strobed word shows in the occupancy at the strobe edge. The status bit follows one edge later and `irq` one edge after that. The bench drives every input at a falling edge and samples at the next falling edge, after exactly one rising edge. It waits idle falling edges for each extra register stage, so the interrupt's two-cycle lag is checked as 0 then 1 rather than simply awaited. For the case where a push and a pop share a cycle, both are driven at the same falling edge.

// File: rtl/smpq_pkg.sv
package smpq_pkg;
  localparam int ADDR_W = 12;
  localparam int BUS_W  = 32;

  localparam logic [ADDR_W-1:0] OFS_GIE  = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 12'h028;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_DATA = 12'h104;
  localparam logic [ADDR_W-1:0] OFS_OCC  = 12'h108;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_GIE, SEL_STAT, SEL_IEN, SEL_CTRL, SEL_DATA, SEL_OCC
  } regsel_e;

  function automatic regsel_e decode_ofs(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_GIE:  return SEL_GIE;
      OFS_STAT: return SEL_STAT;
      OFS_IEN:  return SEL_IEN;
      OFS_CTRL: return SEL_CTRL;
      OFS_DATA: return SEL_DATA;
      OFS_OCC:  return SEL_OCC;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/smpq_fifo.sv
module smpq_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [DW-1:0]                din,
  input  logic                         pop_req,
  output logic [DW-1:0]                dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] dout_q;
  logic push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop_req && !empty;
  assign count   = cnt_q;
  assign dout    = dout_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) dout_q <= '0;
    else if (pop_ok) dout_q <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  assert_full_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop_req) |=> $stable(cnt_q));
  assert_pushpop_R9: assert property (@(posedge clk) disable iff (rst)
    (push && pop_req && !full && !empty) |=> $stable(cnt_q));
endmodule

// File: rtl/smpq_irq.sv
module smpq_irq (
  input  logic clk,
  input  logic rst,
  input  logic nonempty,
  input  logic gie_we,
  input  logic ien_we,
  input  logic stat_we,
  input  logic wbit,
  output logic gie,
  output logic ien,
  output logic stat,
  output logic irq
);
  logic gie_q, ien_q, stat_q, irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q  <= 1'b0;
      ien_q  <= 1'b0;
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (gie_we) gie_q <= wbit;
      if (ien_we) ien_q <= wbit;
      stat_q <= (stat_q ^ (stat_we & wbit)) | nonempty;
      irq_q  <= gie_q & ien_q & stat_q;
    end
  end

  assign gie  = gie_q;
  assign ien  = ien_q;
  assign stat = stat_q;
  assign irq  = irq_q;

  assert_stat_level_R6: assert property (@(posedge clk) disable iff (rst)
    nonempty |=> stat_q);
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(gie_q && ien_q && stat_q));
endmodule

// File: rtl/smpq_regblock.sv
module smpq_regblock
  import smpq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int FSTM_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ack,
  output logic              bus_err,
  output logic [31:0]       bus_rdata,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              conv_en,
  output logic [FSTM_W-1:0] settle_mult,
  output logic              irq
);
  localparam int CTRL_W = FSTM_W + 1;
  localparam int CW     = $clog2(DEPTH+1);

  regsel_e sel;
  logic rd, wr, pop_req;
  logic [DATA_W-1:0] fifo_dout;
  logic [CW-1:0] occ;
  logic f_empty, f_full;
  logic gie, ien, stat;
  logic [CTRL_W-1:0] ctrl_q;
  logic ack_q, err_q, data_sel_q;
  logic [BUS_W-1:0] reg_q, rd_mux;

  assign sel     = decode_ofs(bus_addr);
  assign rd      = bus_req && !bus_we;
  assign wr      = bus_req && bus_we;
  assign pop_req = rd && (sel == SEL_DATA);

  smpq_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(smp_valid), .din(smp_data),
    .pop_req(pop_req), .dout(fifo_dout),
    .count(occ), .empty(f_empty), .full(f_full)
  );

  smpq_irq u_irq (
    .clk(clk), .rst(rst),
    .nonempty(!f_empty),
    .gie_we(wr && sel == SEL_GIE),
    .ien_we(wr && sel == SEL_IEN),
    .stat_we(wr && sel == SEL_STAT),
    .wbit(bus_wdata[0]),
    .gie(gie), .ien(ien), .stat(stat), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr && sel == SEL_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  always_comb begin
    case (sel)
      SEL_GIE:  rd_mux = BUS_W'(gie);
      SEL_STAT: rd_mux = BUS_W'(stat);
      SEL_IEN:  rd_mux = BUS_W'(ien);
      SEL_CTRL: rd_mux = BUS_W'(ctrl_q);
      SEL_OCC:  rd_mux = BUS_W'(occ);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q      <= 1'b0;
      err_q      <= 1'b0;
      data_sel_q <= 1'b0;
      reg_q      <= '0;
    end else begin
      ack_q      <= bus_req;
      err_q      <= pop_req && f_empty;
      data_sel_q <= pop_req && !f_empty;
      reg_q      <= rd ? rd_mux : '0;
    end
  end

  assign bus_ack     = ack_q;
  assign bus_err     = err_q;
  assign bus_rdata   = data_sel_q ? BUS_W'(fifo_dout) : reg_q;
  assign conv_en     = ctrl_q[0];
  assign settle_mult = ctrl_q[CTRL_W-1:1];

  assert_ack_next_R3: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> bus_ack);
  assert_empty_err_R4: assert property (@(posedge clk) disable iff (rst)
    (pop_req && occ == '0) |=> (bus_err && bus_ack));
  assert_err_needs_ack_R4: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> bus_ack);
  assert_ro_write_R10: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_OCC && !smp_valid) |=> $stable(occ));
endmodule

// File: tb/smpq_regblock_test.sv
module smpq_regblock_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ack, bus_err;
  logic [31:0] bus_rdata;
  logic smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic conv_en;
  logic [3:0] settle_mult;
  logic irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;
  logic re, ra;

  always #5 clk = ~clk;

  smpq_regblock uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_err(bus_err), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
    .smp_data(smp_data), .conv_en(conv_en), .settle_mult(settle_mult),
    .irq(irq)
  );

  localparam logic [11:0] A_GIE = 12'h01C, A_STAT = 12'h020, A_IEN = 12'h028,
                          A_CTRL = 12'h100, A_DATA = 12'h104, A_OCC = 12'h108;
  // op: 0 write, 1 read and compare, 2 push sample
  localparam int NV = 21;
  localparam logic [77:0] VEC [NV] = '{
    {2'd1, A_GIE,  32'h0,        32'h0},        // R1
    {2'd1, A_IEN,  32'h0,        32'h0},        // R1
    {2'd1, A_CTRL, 32'h0,        32'h0},        // R1
    {2'd1, A_OCC,  32'h0,        32'h0},        // R1
    {2'd1, A_STAT, 32'h0,        32'h0},        // R1
    {2'd0, A_CTRL, 32'hFFFF_FF17, 32'h0},       // R8
    {2'd1, A_CTRL, 32'h0,        32'h17},       // R8
    {2'd0, A_GIE,  32'hFFFF_FFFF, 32'h0},       // R11
    {2'd1, A_GIE,  32'h0,        32'h1},        // R11
    {2'd0, A_IEN,  32'h0000_0003, 32'h0},       // R11
    {2'd1, A_IEN,  32'h0,        32'h1},        // R11
    {2'd2, 12'h0,  32'h0000_A5C3, 32'h0},       // R3
    {2'd2, 12'h0,  32'h0000_1234, 32'h0},       // R3
    {2'd1, A_OCC,  32'h0,        32'h2},        // R5
    {2'd1, A_DATA, 32'h0,        32'h0000_A5C3}, // R3
    {2'd1, A_DATA, 32'h0,        32'h0000_1234}, // R3
    {2'd1, A_OCC,  32'h0,        32'h0},        // R5
    {2'd0, A_DATA, 32'h0000_DEAD, 32'h0},       // R10
    {2'd0, A_OCC,  32'h0000_0007, 32'h0},       // R10
    {2'd1, A_OCC,  32'h0,        32'h0},        // R10
    {2'd1, 12'h0FC, 32'h0,       32'h0}         // R10
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d,
                          output logic e, output logic k);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; e = bus_err; k = bus_ack;
    bus_req = 1'b0;
  endtask

  task automatic push(input logic [15:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 100000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0 && conv_en == 1'b0 && settle_mult == 4'h0 && bus_ack == 1'b0,
        "R1 outputs", {irq, conv_en, settle_mult, bus_ack}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] op;
      logic [11:0] a;
      logic [31:0] wd, ex;
      {op, a, wd, ex} = VEC[v];
      case (op)
        2'd0: bus_write(a, wd);
        2'd2: push(wd[15:0]);
        default: begin
          bus_read(a, rv, re, ra);
          chk(rv == ex && !re && ra, $sformatf("R3/vector %0d", v), rv, ex);
        end
      endcase
    end
    chk(conv_en == 1'b1 && settle_mult == 4'hB, "R8 pins",
        {27'h0, settle_mult, conv_en}, 32'h17);

    // R6: sticky after empty, toggled by writing 1
    bus_read(A_STAT, rv, re, ra);
    chk(rv == 32'h1, "R6 sticky", rv, 32'h1);
    chk(irq == 1'b1, "R7 irq on", {31'h0, irq}, 32'h1);
    bus_write(A_STAT, 32'h1);
    @(negedge clk);
    bus_read(A_STAT, rv, re, ra);
    chk(rv == 32'h0, "R6 toggle off", rv, 32'h0);
    chk(irq == 1'b0, "R7 irq off", {31'h0, irq}, 32'h0);
    bus_write(A_STAT, 32'h1);
    bus_read(A_STAT, rv, re, ra);
    chk(rv == 32'h1, "R6 toggle on", rv, 32'h1);
    bus_write(A_STAT, 32'h1);
    @(negedge clk);

    // R7: two-cycle lag from a push, then gating
    push(16'h0BEE);
    chk(irq == 1'b0, "R7 lag stage", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk(irq == 1'b0, "R7 lag stage2", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk(irq == 1'b1, "R7 asserted", {31'h0, irq}, 32'h1);
    bus_write(A_IEN, 32'h0);
    @(negedge clk);
    chk(irq == 1'b0, "R7 ien gate", {31'h0, irq}, 32'h0);
    bus_write(A_IEN, 32'h1);
    bus_write(A_GIE, 32'h0);
    @(negedge clk);
    chk(irq == 1'b0, "R7 gie gate", {31'h0, irq}, 32'h0);
    bus_read(A_DATA, rv, re, ra);
    chk(rv == 32'h0000_0BEE && !re, "R3 pop", rv, 32'h0BEE);

    // R4: empty read
    bus_read(A_DATA, rv, re, ra);
    chk(re == 1'b1 && ra == 1'b1, "R4 err", {30'h0, re, ra}, 32'h3);
    bus_read(A_OCC, rv, re, ra);
    chk(rv == 32'h0, "R4 occupancy", rv, 32'h0);

    // R2: overflow by one
    for (int i = 0; i < 17; i++) push(16'(i * 16'h0111 + 16'h7));
    bus_read(A_OCC, rv, re, ra);
    chk(rv == 32'd16, "R5 full count", rv, 32'd16);
    for (int i = 0; i < 16; i++) begin
      bus_read(A_DATA, rv, re, ra);
      chk(rv == 32'(16'(i * 16'h0111 + 16'h7)) && !re, "R2 order", rv,
          32'(16'(i * 16'h0111 + 16'h7)));
    end
    bus_read(A_DATA, rv, re, ra);
    chk(re == 1'b1, "R2 dropped", {31'h0, re}, 32'h1);

    // R9: push and pop together
    push(16'h1111);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 16'h2222;
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = A_DATA;
    @(negedge clk);
    rv = bus_rdata;
    smp_valid = 1'b0; bus_req = 1'b0;
    chk(rv == 32'h1111, "R9 popped", rv, 32'h1111);
    bus_read(A_OCC, rv, re, ra);
    chk(rv == 32'h1, "R9 count", rv, 32'h1);
    bus_read(A_DATA, rv, re, ra);
    chk(rv == 32'h2222, "R9 pushed", rv, 32'h2222);

    // R1: reset again
    push(16'h5555);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    bus_read(A_OCC, rv, re, ra);
    chk(rv == 32'h0, "R1 occupancy", rv, 32'h0);
    bus_read(A_STAT, rv, re, ra);
    chk(rv == 32'h0, "R1 status", rv, 32'h0);
    bus_read(A_CTRL, rv, re, ra);
    chk(rv == 32'h0 && conv_en == 1'b0, "R1 control", rv, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule